// File: doc/BRIEF.md
# Indirect Control/Status Register Bank with Interrupt Logic

This block is the host-visible register bank of an Ethernet controller. Software reaches it through a 16-bit bus window with two word offsets. A pointer register at offset 1 selects one of four internal registers. The data port at offset 0 then reads or writes the selected register. The bank holds the following:

- the main command/status register, which carries the start, init and stop commands, the run state, the event flags and the interrupt enable;
- two halves of a 32-bit pointer to the controller's initialization block;
- one bus-mode register.

The receive and transmit engines report completed frames with single-cycle pulses. The bank turns those pulses into sticky flags, keeps the error and interrupt summary bits up to date, and raises one interrupt line when the summary is set and interrupts are enabled. The run state and the assembled init pointer are driven out to the rest of the controller.

Top module: `nic_csr_block`

## Requirements
- R1: Word offset 0 (busOfs=0) reads and writes the register that the pointer selects (0 command/status, 1 pointer low half, 2 pointer high half, 3 bus mode). Word offset 1 reads and writes the pointer itself, and a read returns it zero-extended to 16 bits.
- R2: A pointer write takes effect only if the written value is less than 4. Any larger value leaves the pointer unchanged.
- R3: A write to register 0 with bit 2 (stop) set loads exactly 0x0004. All other written bits are discarded, and so are any receive or transmit event pulses in the same cycle.
- R4: In a register-0 write without stop, a 1 in any of bits 14..8 clears that flag and a 0 keeps it. If an event pulse for a flag arrives in the same cycle as its clear, the flag stays set.
- R5: Bit 15 reads as the OR of bits 14..11, and bit 7 reads as the OR of bits 14..8. Writing either bit has no effect.
- R6: In a register-0 write without stop, bit 6 (interrupt enable) takes the written value.
- R7: In a register-0 write without stop, bit 0 (init) sets bits 0 and 8 and clears bit 2. If bit 0 is not written and bit 1 (start) is, bits 1, 5 (rx on) and 4 (tx on) are set and bit 2 is cleared. The outputs stopped, rxOn and txOn follow bits 2, 5 and 4. Command bits that are already set stay set.
- R8: A write to register 1 loads initPtr[15:0], and a write to register 2 loads initPtr[31:16]. Register 3 keeps the full 16-bit value written to it. Each of these registers reads back through the data port.
- R9: After reset, register 0 reads 0x0004 and the pointer, initPtr and register 3 read 0.
- R10: A receive-done pulse sets bit 10, and a transmit-done pulse sets bit 9. Either pulse therefore sets bit 7.
- R11: irqOut is high exactly when bits 7 and 6 of register 0 are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access strobe |
| busWr | input | 1 | 1 = write, 0 = read |
| busOfs | input | 1 | Word offset: 0 data port, 1 pointer |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data for the current offset |
| rxDoneEv | input | 1 | Receive-complete pulse |
| txDoneEv | input | 1 | Transmit-complete pulse |
| irqOut | output | 1 | Interrupt request |
| stopped | output | 1 | Controller is stopped |
| rxOn | output | 1 | Receiver enabled |
| txOn | output | 1 | Transmitter enabled |
| initPtr | output | 32 | Initialization block pointer |

## Verification
The hardest case to reach from the ports is a register-0 write that lands in the same cycle as an engine pulse. The write can clear the same flag that the pulse sets, or it can be a stop command that has to discard the pulse. The bench reaches this case with a write task that raises the event pulses during the same low clock phase as the write strobe, so both are sampled on one edge. Before that, it first puts the flags into a known mix of set and clear states, so the result shows which source won.

// File: rtl/nic_csr_pkg.sv
package nic_csr_pkg;
  localparam int CSR_W  = 16;
  localparam int REG_NUM = 4;
  localparam int RAP_W  = $clog2(REG_NUM);
  localparam int PTR_W  = 2 * CSR_W;

  // command/status register bit positions
  localparam int B_ERR  = 15;
  localparam int B_FHI  = 14;
  localparam int B_EHI  = 14;
  localparam int B_ELO  = 11;
  localparam int B_RINT = 10;
  localparam int B_TINT = 9;
  localparam int B_IDON = 8;
  localparam int B_FLO  = 8;
  localparam int B_INTR = 7;
  localparam int B_INEA = 6;
  localparam int B_RXON = 5;
  localparam int B_TXON = 4;
  localparam int B_STOP = 2;
  localparam int B_STRT = 1;
  localparam int B_INIT = 0;
  localparam int FLAG_N = B_FHI - B_FLO + 1;

  localparam int REG_CMD = 0;
  localparam int REG_PLO = 1;
  localparam int REG_PHI = 2;
  localparam int REG_MOD = 3;

  typedef struct packed {
    logic               stopCmd;
    logic [REG_NUM-1:0] regWr;
  } csr_strobe_t;
endpackage

// File: rtl/nic_csr_ctrl.sv
module nic_csr_ctrl
  import nic_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             busSel,
  input  logic             busWr,
  input  logic             busOfs,
  input  logic [CSR_W-1:0] busWdata,
  input  logic [CSR_W-1:0] dataPortRd,
  output logic [CSR_W-1:0] busRdata,
  output logic [RAP_W-1:0] rapNow,
  output csr_strobe_t      strobes
);
  logic [RAP_W-1:0] rapQ;
  logic             wrAny;
  logic             rapAccept;

  assign wrAny     = busSel && busWr;
  assign rapAccept = wrAny && busOfs && (busWdata < CSR_W'(REG_NUM));

  always_ff @(posedge clk) begin
    if (!rstN) rapQ <= '0;
    else if (rapAccept) rapQ <= busWdata[RAP_W-1:0];
  end

  for (genvar g = 0; g < REG_NUM; g++) begin : gDecode
    assign strobes.regWr[g] = wrAny && !busOfs && (rapQ == RAP_W'(g));
  end

  assign strobes.stopCmd = strobes.regWr[REG_CMD] && busWdata[B_STOP];
  assign rapNow   = rapQ;
  assign busRdata = busOfs ? {{(CSR_W-RAP_W){1'b0}}, rapQ} : dataPortRd;
endmodule

// File: rtl/nic_csr_dpath.sv
module nic_csr_dpath
  import nic_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  csr_strobe_t      strobes,
  input  logic [CSR_W-1:0] wdata,
  input  logic [RAP_W-1:0] rapNow,
  input  logic             rxDoneEv,
  input  logic             txDoneEv,
  output logic [CSR_W-1:0] dataPortRd,
  output logic [CSR_W-1:0] csr0View,
  output logic             irqOut,
  output logic             stopped,
  output logic             rxOn,
  output logic             txOn,
  output logic [PTR_W-1:0] initPtr
);
  logic [FLAG_N-1:0] flagQ, flagD;
  logic ineaQ, ineaD, rxOnQ, rxOnD, txOnQ, txOnD;
  logic stopQ, stopD, strtQ, strtD, initQ, initD;
  logic [PTR_W-1:0] ptrQ;
  logic [CSR_W-1:0] modeQ;
  logic errSum, intSum;
  logic [CSR_W-1:0] regView [REG_NUM];

  always_comb begin
    flagD = flagQ; ineaD = ineaQ; rxOnD = rxOnQ; txOnD = txOnQ;
    stopD = stopQ; strtD = strtQ; initD = initQ;
    if (strobes.stopCmd) begin
      flagD = '0; ineaD = 1'b0; rxOnD = 1'b0; txOnD = 1'b0;
      strtD = 1'b0; initD = 1'b0; stopD = 1'b1;
    end else begin
      if (strobes.regWr[REG_CMD]) begin
        flagD = flagQ & ~wdata[B_FHI:B_FLO];
        ineaD = wdata[B_INEA];
        if (wdata[B_INIT]) begin
          initD = 1'b1;
          flagD[B_IDON-B_FLO] = 1'b1;
          stopD = 1'b0;
        end else if (wdata[B_STRT]) begin
          strtD = 1'b1; rxOnD = 1'b1; txOnD = 1'b1;
          stopD = 1'b0;
        end
      end
      if (rxDoneEv) flagD[B_RINT-B_FLO] = 1'b1;
      if (txDoneEv) flagD[B_TINT-B_FLO] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ <= '0; ineaQ <= 1'b0; rxOnQ <= 1'b0; txOnQ <= 1'b0;
      stopQ <= 1'b1; strtQ <= 1'b0; initQ <= 1'b0;
    end else begin
      flagQ <= flagD; ineaQ <= ineaD; rxOnQ <= rxOnD; txOnQ <= txOnD;
      stopQ <= stopD; strtQ <= strtD; initQ <= initD;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrQ  <= '0;
      modeQ <= '0;
    end else begin
      if (strobes.regWr[REG_PLO]) ptrQ[CSR_W-1:0]     <= wdata;
      if (strobes.regWr[REG_PHI]) ptrQ[PTR_W-1:CSR_W] <= wdata;
      if (strobes.regWr[REG_MOD]) modeQ               <= wdata;
    end
  end

  assign errSum = |flagQ[B_EHI-B_FLO:B_ELO-B_FLO];
  assign intSum = |flagQ;

  always_comb begin
    csr0View         = '0;
    csr0View[B_ERR]  = errSum;
    csr0View[B_FHI:B_FLO] = flagQ;
    csr0View[B_INTR] = intSum;
    csr0View[B_INEA] = ineaQ;
    csr0View[B_RXON] = rxOnQ;
    csr0View[B_TXON] = txOnQ;
    csr0View[B_STOP] = stopQ;
    csr0View[B_STRT] = strtQ;
    csr0View[B_INIT] = initQ;
  end

  assign regView[REG_CMD] = csr0View;
  assign regView[REG_PLO] = ptrQ[CSR_W-1:0];
  assign regView[REG_PHI] = ptrQ[PTR_W-1:CSR_W];
  assign regView[REG_MOD] = modeQ;

  assign dataPortRd = regView[rapNow];
  assign irqOut     = intSum && ineaQ;
  assign stopped    = stopQ;
  assign rxOn       = rxOnQ;
  assign txOn       = txOnQ;
  assign initPtr    = ptrQ;
endmodule

// File: rtl/nic_csr_block.sv
module nic_csr_block
  import nic_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             busSel,
  input  logic             busWr,
  input  logic             busOfs,
  input  logic [CSR_W-1:0] busWdata,
  output logic [CSR_W-1:0] busRdata,
  input  logic             rxDoneEv,
  input  logic             txDoneEv,
  output logic             irqOut,
  output logic             stopped,
  output logic             rxOn,
  output logic             txOn,
  output logic [PTR_W-1:0] initPtr
);
  csr_strobe_t      strobes;
  logic [RAP_W-1:0] rapNow;
  logic [CSR_W-1:0] dataPortRd;
  logic [CSR_W-1:0] csr0View;

  nic_csr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busOfs(busOfs), .busWdata(busWdata), .dataPortRd(dataPortRd),
    .busRdata(busRdata), .rapNow(rapNow), .strobes(strobes)
  );

  nic_csr_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wdata(busWdata),
    .rapNow(rapNow), .rxDoneEv(rxDoneEv), .txDoneEv(txDoneEv),
    .dataPortRd(dataPortRd), .csr0View(csr0View), .irqOut(irqOut),
    .stopped(stopped), .rxOn(rxOn), .txOn(txOn), .initPtr(initPtr)
  );
endmodule

// File: rtl/nic_csr_chk.sv
module nic_csr_chk
  import nic_csr_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             busSel,
  input logic             busWr,
  input logic             busOfs,
  input logic [CSR_W-1:0] busWdata,
  input logic             rxDoneEv,
  input logic             txDoneEv,
  input logic             irqOut,
  input logic [RAP_W-1:0] rapNow,
  input logic [CSR_W-1:0] csr0View
);
  logic cmdWr;
  assign cmdWr = busSel && busWr && !busOfs && (rapNow == RAP_W'(REG_CMD));

  AST_RAP_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && busOfs && busWdata >= CSR_W'(REG_NUM)) |=> $stable(rapNow)); // R2

  AST_STOP_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && busWdata[B_STOP]) |=> (csr0View == 16'h0004)); // R3

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (rxDoneEv && !(cmdWr && busWdata[B_STOP])) |=> (csr0View[B_RINT] && csr0View[B_INTR])); // R4

  AST_TX_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    (txDoneEv && !(cmdWr && busWdata[B_STOP])) |=> (csr0View[B_TINT] && csr0View[B_INTR])); // R10

  AST_INEA_DIRECT: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && !busWdata[B_STOP]) |=> (csr0View[B_INEA] == $past(busWdata[B_INEA]))); // R6

  AST_INIT_CMD: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && !busWdata[B_STOP] && busWdata[B_INIT])
      |=> (csr0View[B_INIT] && csr0View[B_IDON] && !csr0View[B_STOP])); // R7

  AST_IRQ_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (csr0View[B_INEA] && csr0View[B_INTR])); // R11
endmodule

bind nic_csr_block nic_csr_chk u_chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busOfs(busOfs),
  .busWdata(busWdata), .rxDoneEv(rxDoneEv), .txDoneEv(txDoneEv),
  .irqOut(irqOut), .rapNow(rapNow), .csr0View(csr0View)
);

// File: tb/nic_csr_block_test.sv
module nic_csr_block_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0, busWr = 1'b0, busOfs = 1'b0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic rxDoneEv = 1'b0, txDoneEv = 1'b0;
  logic irqOut, stopped, rxOn, txOn;
  logic [31:0] initPtr;
  int nChecks = 0, nFail = 0;

  always #10 clk = ~clk;

  nic_csr_block uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busOfs(busOfs),
    .busWdata(busWdata), .busRdata(busRdata), .rxDoneEv(rxDoneEv),
    .txDoneEv(txDoneEv), .irqOut(irqOut), .stopped(stopped), .rxOn(rxOn),
    .txOn(txOn), .initPtr(initPtr)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wrEv(logic ofs, logic [15:0] d, logic rx, logic tx);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busOfs = ofs; busWdata = d;
    rxDoneEv = rx; txDoneEv = tx;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0; rxDoneEv = 1'b0; txDoneEv = 1'b0;
  endtask

  task automatic wr(logic ofs, logic [15:0] d);
    wrEv(ofs, d, 1'b0, 1'b0);
  endtask

  task automatic pulse(logic rx, logic tx);
    @(negedge clk);
    rxDoneEv = rx; txDoneEv = tx;
    @(negedge clk);
    rxDoneEv = 1'b0; txDoneEv = 1'b0;
  endtask

  task automatic rd(logic ofs, output logic [15:0] v);
    busOfs = ofs; busSel = 1'b1; busWr = 1'b0;
    #1 v = busRdata;
    busSel = 1'b0;
  endtask

  task automatic testReset();
    logic [15:0] v;
    rd(1'b0, v); check("R9 csr0", v, 16'h0004);
    rd(1'b1, v); check("R9 pointer", v, 0);
    check("R9 initPtr", initPtr, 0);
    check("R9/R7 stopped", stopped, 1);
    check("R11 irq at reset", irqOut, 0);
  endtask

  task automatic testPointerAndRegs();
    logic [15:0] v;
    wr(1'b1, 16'd3);
    rd(1'b1, v); check("R1 pointer read", v, 16'd3);
    rd(1'b0, v); check("R9 reg3 reset", v, 0);
    wr(1'b1, 16'd5);
    rd(1'b1, v); check("R2 reject 5", v, 16'd3);
    wr(1'b1, 16'd4);
    rd(1'b1, v); check("R2 reject 4", v, 16'd3);
    wr(1'b1, 16'h8001);
    rd(1'b1, v); check("R2 reject large", v, 16'd3);
    wr(1'b0, 16'hA5C3);
    rd(1'b0, v); check("R8 reg3 stored", v, 16'hA5C3);
    wr(1'b1, 16'd1); wr(1'b0, 16'hBEEF);
    wr(1'b1, 16'd2); wr(1'b0, 16'h1234);
    check("R8 initPtr", initPtr, 32'h1234BEEF);
    rd(1'b0, v); check("R8 high readback", v, 16'h1234);
    wr(1'b1, 16'd1);
    rd(1'b0, v); check("R1 low readback", v, 16'hBEEF);
    check("R3 ptr write not csr0", stopped, 1);
    wr(1'b1, 16'd0);
  endtask

  task automatic testInitStart();
    logic [15:0] v;
    wr(1'b0, 16'h0041);
    rd(1'b0, v); check("R7 init", v, 16'h01C1);
    check("R11 irq on", irqOut, 1);
    check("R7 not stopped", stopped, 0);
    wr(1'b0, 16'h0140);
    rd(1'b0, v); check("R4 clear idon", v, 16'h0041);
    check("R11 irq off", irqOut, 0);
    wr(1'b0, 16'h0000);
    rd(1'b0, v); check("R6 inea cleared", v, 16'h0001);
    wr(1'b0, 16'h0042);
    rd(1'b0, v); check("R7 start", v, 16'h0073);
    check("R7 rxOn", rxOn, 1);
    check("R7 txOn", txOn, 1);
    wr(1'b0, 16'h0004);
    rd(1'b0, v); check("R3 stop", v, 16'h0004);
    check("R7 rxOn after stop", rxOn, 0);
    wr(1'b0, 16'h0003);
    rd(1'b0, v); check("R7 init beats start", v, 16'h0181);
    check("R7 rxOn stays off", rxOn, 0);
  endtask

  task automatic testEvents();
    logic [15:0] v;
    pulse(1'b1, 1'b0);
    rd(1'b0, v); check("R10 rx event", v, 16'h0581);
    check("R11 irq masked", irqOut, 0);
    pulse(1'b0, 1'b1);
    rd(1'b0, v); check("R10 tx event", v, 16'h0781);
    wr(1'b0, 16'h0440);
    rd(1'b0, v); check("R4 clear rint", v, 16'h03C1);
    check("R11 irq enabled", irqOut, 1);
    wrEv(1'b0, 16'h0200, 1'b0, 1'b1);
    rd(1'b0, v); check("R4 event beats clear", v, 16'h0381);
    wr(1'b0, 16'h8080);
    rd(1'b0, v); check("R5 summary not writable", v, 16'h0381);
    wr(1'b0, 16'h0300);
    rd(1'b0, v); check("R5 intr drops", v, 16'h0001);
    wrEv(1'b0, 16'h0044, 1'b1, 1'b1);
    rd(1'b0, v); check("R3 stop discards events", v, 16'h0004);
    check("R11 irq after stop", irqOut, 0);
  endtask

  initial begin
    #(20 * 100000);
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPointerAndRegs();
    testInitStart();
    testEvents();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule